// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces the periodic refresh of an SDRAM array. A two-bit rate code picks one of three refresh periods or turns refresh off, and a two-bit clock code tells the timer which bus frequency it runs at. The timer turns the chosen period into a count of clock cycles, counts it down, and raises a refresh request each time the period runs out.

The request is a level. It stays high until the command sequencer that issues the auto-refresh command returns an acknowledge pulse. If further periods run out before the sequencer answers, the timer keeps a small saturating count of owed refreshes. The sequencer can then catch up without losing any of them. Changing either code restarts the period from the full new length. Rate code 00 stops all counting and discards any refreshes still owed.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `refresh_req` is 0 and `pending_cnt` is 0.
- R2: When `rate_sel` is 00 at a clock edge, the owed count is cleared at that edge. No request is produced for as long as the code stays 00, whatever `refresh_ack` does.
- R3: Rate code 01 gives a period of floor(7.8 us x f) cycles. At clock code 00 (66 MHz) this is 514 cycles, at 01 (100 MHz) 780 cycles, and at 10 (133 MHz) 1037 cycles.
- R4: Rate code 10 gives floor(15.6 us x f) cycles: 1029, 1560 and 2074. Rate code 11 gives floor(125 us x f) cycles: 8250, 12500 and 16625. Clock code 11 is treated exactly like 10 (133 MHz).
- R5: When `rate_sel` or `clk_sel` changes value at edge k, with the new rate code nonzero, the first expiry happens at edge k+N, where N is the period for the new pair. Later expiries follow every N edges.
- R6: At each expiry the owed count `pending_cnt` rises by one. An acknowledge sampled while the count is nonzero lowers it by one. `refresh_req` is high exactly when the count is nonzero.
- R7: The owed count saturates at 3. Further expiries with no acknowledge leave it at 3.
- R8: An acknowledge sampled while the count is 0 has no effect. It neither changes the count nor shifts the timing of the next expiry.
- R9: An expiry and an acknowledge at the same edge, with a nonzero count, leave the count unchanged. With a zero count, the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Refresh period code: 00 off, 01 7.8 us, 10 15.6 us, 11 125 us |
| clk_sel | input | 2 | Clock frequency code: 00 66 MHz, 01 100 MHz, 10 and 11 133 MHz |
| refresh_ack | input | 1 | One-cycle acknowledge from the command sequencer |
| refresh_req | output | 1 | High while at least one refresh is owed |
| pending_cnt | output | 2 | Number of refreshes owed, saturating at 3 |

## Verification
Two things can happen at the same clock edge: a period runs out and the sequencer acknowledges. They can move the owed count in opposite directions. The bench sets up this collision on purpose by waiting exactly one period after a known restart, then asserts the acknowledge so that it lands on the expiry edge. The count must stay where it was. If it was zero, it must become one. The behavioural model in the bench makes the same decision at every edge of the saturation, restart and disable sequences.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [1:0] {
    RATE_OFF   = 2'b00,
    RATE_SHORT = 2'b01,
    RATE_MID   = 2'b10,
    RATE_LONG  = 2'b11
  } rate_code_e;

  // period in tenths of a microsecond times clock in MHz, floored
  function automatic int unsigned interval_cycles(input int unsigned tenths_us,
                                                  input int unsigned mhz);
    return (tenths_us * mhz) / 10;
  endfunction

  function automatic int unsigned bits_for(input int unsigned value);
    return $clog2(value + 1);
  endfunction

endpackage

// File: rtl/ref_reload_table.sv
module ref_reload_table
  import sdram_ref_pkg::*;
#(
  parameter int unsigned TENTHS_SHORT = 78,
  parameter int unsigned TENTHS_MID   = 156,
  parameter int unsigned TENTHS_LONG  = 1250,
  parameter int unsigned MHZ_SLOW     = 66,
  parameter int unsigned MHZ_MID      = 100,
  parameter int unsigned MHZ_FAST     = 133,
  parameter int unsigned CNT_W        = 15
) (
  input  logic [1:0]       rate_sel,
  input  logic [1:0]       clk_sel,
  output logic             enable,
  output logic [CNT_W-1:0] reload
);

  localparam int unsigned N_ROWS = 4;
  localparam int unsigned N_COLS = 3;

  logic [CNT_W-1:0] tbl [N_ROWS][N_COLS];
  logic [1:0]       col_idx;

  for (genvar gr = 0; gr < N_ROWS; gr++) begin : g_row
    for (genvar gc = 0; gc < N_COLS; gc++) begin : g_col
      localparam int unsigned TENTHS = (gr == 1) ? TENTHS_SHORT :
                                       (gr == 2) ? TENTHS_MID   :
                                       (gr == 3) ? TENTHS_LONG  : 0;
      localparam int unsigned MHZ    = (gc == 0) ? MHZ_SLOW :
                                       (gc == 1) ? MHZ_MID  : MHZ_FAST;
      if (gr == 0) begin : g_off
        assign tbl[gr][gc] = '0;
      end else begin : g_on
        assign tbl[gr][gc] = CNT_W'(interval_cycles(TENTHS, MHZ));
      end
    end
  end

  always_comb begin
    col_idx = (clk_sel == 2'd3) ? 2'd2 : clk_sel;
    enable  = (rate_sel != RATE_OFF);
    reload  = tbl[rate_sel][col_idx];
  end

endmodule

// File: rtl/ref_interval_counter.sv
module ref_interval_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       rate_sel,
  input  logic [1:0]       clk_sel,
  input  logic [CNT_W-1:0] reload,
  output logic             expire,
  output logic             cfg_change
);

  logic [CNT_W-1:0] remain_q;
  logic [3:0]       cfg_q;
  logic [3:0]       cfg_now;
  logic [CNT_W-1:0] reload_m1;

  always_comb begin
    cfg_now    = {rate_sel, clk_sel};
    cfg_change = (cfg_now != cfg_q);
    reload_m1  = reload - CNT_W'(1);
    expire     = enable && !cfg_change && (remain_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      cfg_q    <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (!enable) begin
        remain_q <= '0;
      end else if (cfg_change || remain_q == '0) begin
        remain_q <= reload_m1;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ref_pending_tracker.sv
module ref_pending_tracker #(
  parameter int unsigned PEND_MAX = 3,
  parameter int unsigned PEND_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              expire,
  input  logic              ack,
  output logic [PEND_W-1:0] pend,
  output logic              req
);

  logic [PEND_W-1:0] pend_q;
  logic              take;
  logic              full;

  always_comb begin
    take = ack && (pend_q != '0);
    full = (pend_q == PEND_W'(PEND_MAX));
    pend = pend_q;
    req  = (pend_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (!enable) begin
      pend_q <= '0;
    end else if (expire && !take) begin
      if (!full) pend_q <= pend_q + PEND_W'(1);
    end else if (take && !expire) begin
      pend_q <= pend_q - PEND_W'(1);
    end
  end

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
  import sdram_ref_pkg::*;
#(
  parameter int unsigned TENTHS_SHORT = 78,
  parameter int unsigned TENTHS_MID   = 156,
  parameter int unsigned TENTHS_LONG  = 1250,
  parameter int unsigned MHZ_SLOW     = 66,
  parameter int unsigned MHZ_MID      = 100,
  parameter int unsigned MHZ_FAST     = 133,
  parameter int unsigned PEND_MAX     = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [1:0]                           rate_sel,
  input  logic [1:0]                           clk_sel,
  input  logic                                 refresh_ack,
  output logic                                 refresh_req,
  output logic [$clog2(PEND_MAX+1)-1:0]        pending_cnt
);

  localparam int unsigned MAX_CYC = interval_cycles(TENTHS_LONG, MHZ_FAST);
  localparam int unsigned CNT_W   = bits_for(MAX_CYC);
  localparam int unsigned PEND_W  = $clog2(PEND_MAX + 1);

  logic             period_on;
  logic [CNT_W-1:0] period_len;
  logic             interval_tick;
  logic             cfg_change;

  ref_reload_table #(
    .TENTHS_SHORT(TENTHS_SHORT),
    .TENTHS_MID  (TENTHS_MID),
    .TENTHS_LONG (TENTHS_LONG),
    .MHZ_SLOW    (MHZ_SLOW),
    .MHZ_MID     (MHZ_MID),
    .MHZ_FAST    (MHZ_FAST),
    .CNT_W       (CNT_W)
  ) table_i (
    .rate_sel(rate_sel),
    .clk_sel (clk_sel),
    .enable  (period_on),
    .reload  (period_len)
  );

  ref_interval_counter #(
    .CNT_W(CNT_W)
  ) counter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (period_on),
    .rate_sel  (rate_sel),
    .clk_sel   (clk_sel),
    .reload    (period_len),
    .expire    (interval_tick),
    .cfg_change(cfg_change)
  );

  ref_pending_tracker #(
    .PEND_MAX(PEND_MAX),
    .PEND_W  (PEND_W)
  ) tracker_i (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(period_on),
    .expire(interval_tick),
    .ack   (refresh_ack),
    .pend  (pending_cnt),
    .req   (refresh_req)
  );

endmodule

// File: rtl/refresh_timer_checker.sv
module refresh_timer_checker #(
  parameter int unsigned PEND_MAX = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [1:0]                        rate_sel,
  input logic                              refresh_ack,
  input logic                              refresh_req,
  input logic [$clog2(PEND_MAX+1)-1:0]     pending_cnt,
  input logic                              tick,
  input logic                              cfg_change
);

  // R2: an off code empties the owed count at the next edge
  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b00) |=> (pending_cnt == '0 && !refresh_req));

  // R5: a restart cannot expire on the following edge
  a_r5_restart_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_change && rate_sel != 2'b00) |=> !tick);

  // R6: an expiry without acknowledge adds one owed refresh
  a_r6_expiry_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !refresh_ack && int'(pending_cnt) < int'(PEND_MAX))
      |=> (int'(pending_cnt) == int'($past(pending_cnt)) + 1));

  // R7: the count holds at its ceiling
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pending_cnt) == int'(PEND_MAX) && !refresh_ack && rate_sel != 2'b00)
      |=> (int'(pending_cnt) == int'(PEND_MAX)));

  // R8: acknowledge with nothing owed is ignored
  a_r8_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && pending_cnt == '0 && !tick && rate_sel != 2'b00)
      |=> (pending_cnt == '0));

  // R9: expiry and acknowledge together cancel
  a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && refresh_ack && pending_cnt != '0)
      |=> (pending_cnt == $past(pending_cnt)));

endmodule

bind sdram_refresh_timer refresh_timer_checker #(
  .PEND_MAX(PEND_MAX)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_sel   (rate_sel),
  .refresh_ack(refresh_ack),
  .refresh_req(refresh_req),
  .pending_cnt(pending_cnt),
  .tick       (interval_tick),
  .cfg_change (cfg_change)
);

// File: tb/sdram_refresh_timer_tb.sv
`timescale 1ns/1ps
module sdram_refresh_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] clk_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic [1:0] pending_cnt;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  string tag = "R6";

  // behavioural model state
  int m_pend = 0;
  int m_elapsed = 0;
  int m_prev_rate = 0;
  int m_prev_clk = 0;

  always #2 clk = ~clk;

  sdram_refresh_timer dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .clk_sel(clk_sel),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .pending_cnt(pending_cnt)
  );

  function automatic int period(input int r, input int c);
    int cc;
    cc = (c == 3) ? 2 : c;
    case (r)
      1: return (cc == 0) ? 514  : (cc == 1) ? 780   : 1037;
      2: return (cc == 0) ? 1029 : (cc == 1) ? 1560  : 2074;
      3: return (cc == 0) ? 8250 : (cc == 1) ? 12500 : 16625;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_elapsed = 0; m_prev_rate = 0; m_prev_clk = 0;
    end else begin
      int r, c, fired;
      r = int'(rate_sel); c = int'(clk_sel); fired = 0;
      if (r == 0) begin
        m_pend = 0; m_elapsed = 0;
      end else begin
        if (r != m_prev_rate || c != m_prev_clk) m_elapsed = 0;
        else begin
          m_elapsed++;
          if (m_elapsed == period(r, c)) begin fired = 1; m_elapsed = 0; end
        end
        m_pend = m_pend + fired - ((refresh_ack && m_pend > 0) ? 1 : 0);
        if (m_pend > 3) m_pend = 3;
      end
      m_prev_rate = r; m_prev_clk = c;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (int'(pending_cnt) != m_pend || refresh_req != (m_pend > 0)) begin
        bad++;
        $display("FAIL %s model: pend=%0d req=%0b expected pend=%0d req=%0b",
                 tag, pending_cnt, refresh_req, m_pend, (m_pend > 0));
      end
    end
  end

  task automatic check_pend(input string t, input int exp);
    total++;
    if (int'(pending_cnt) != exp || refresh_req != (exp > 0)) begin
      bad++;
      $display("FAIL %s: pend=%0d req=%0b expected pend=%0d req=%0b",
               t, pending_cnt, refresh_req, exp, (exp > 0));
    end
  endtask

  // restart from off, then see the first expiry land at exactly N edges
  task automatic check_interval(input int r, input int c, input string t);
    int n;
    n = period(r, c);
    tag = t;
    @(negedge clk); rate_sel = 2'b00;
    @(negedge clk); rate_sel = 2'(r); clk_sel = 2'(c);
    repeat (n) @(negedge clk);
    check_pend(t, 0);
    @(negedge clk);
    check_pend(t, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_pend("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_pend("R1", 0);

    check_interval(1, 0, "R3");
    check_interval(1, 1, "R3");
    check_interval(1, 2, "R3");
    check_interval(2, 0, "R4");
    check_interval(2, 1, "R4");
    check_interval(2, 2, "R4");
    check_interval(3, 0, "R4");
    check_interval(3, 1, "R4");
    check_interval(3, 2, "R4");
    check_interval(3, 3, "R4");

    // R5: clock code change mid-period restarts the count
    tag = "R5";
    @(negedge clk); rate_sel = 2'b00;
    @(negedge clk); rate_sel = 2'b01; clk_sel = 2'b00;
    repeat (300) @(negedge clk);
    clk_sel = 2'b01;
    repeat (780) @(negedge clk);
    check_pend("R5", 0);
    @(negedge clk);
    check_pend("R5", 1);

    // R7: no acknowledge for several periods (514 each at 66 MHz)
    tag = "R7";
    @(negedge clk); rate_sel = 2'b00;
    @(negedge clk); rate_sel = 2'b01; clk_sel = 2'b00;
    repeat (514 * 5 + 3) @(negedge clk);
    check_pend("R7", 3);

    // R6: one acknowledge lowers the count by one
    tag = "R6";
    refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
    check_pend("R6", 2);
    refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
    check_pend("R6", 1);

    // R2: off code clears and stays silent despite acknowledges
    tag = "R2";
    rate_sel = 2'b00;
    @(negedge clk);
    check_pend("R2", 0);
    for (int i = 0; i < 2000; i++) begin
      refresh_ack = (i % 7 == 0);
      @(negedge clk);
    end
    refresh_ack = 1'b0;
    check_pend("R2", 0);

    // R8: acknowledges with nothing owed change nothing, timing intact
    tag = "R8";
    rate_sel = 2'b01; clk_sel = 2'b01;
    for (int i = 0; i < 780; i++) begin
      refresh_ack = (i % 3 == 1) && (i < 770);
      @(negedge clk);
      if (i == 400) check_pend("R8", 0);
    end
    refresh_ack = 1'b0;
    check_pend("R8", 0);
    @(negedge clk);
    check_pend("R8", 1);

    // R9: acknowledge lands on the next expiry edge
    tag = "R9";
    repeat (779) @(negedge clk);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check_pend("R9", 1);

    // R9: collision with nothing owed gives one
    refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
    check_pend("R9", 0);
    repeat (778) @(negedge clk);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check_pend("R9", 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule